// File: doc/BRIEF.md
# Four-Phase Accumulator Processor Core

This block is a very small accumulator processor. It has 32-bit words and a 32-word store. The datapath is word-parallel, and every instruction takes the same four phases. The phases are paced by a slow, lopsided enable waveform. A counter running on the fast system clock derives that waveform. A one-cycle phase strobe marks each rising edge of the enable, and every register in the core changes only on that strobe. The core therefore stays in one clock domain while an instruction takes thousands of system cycles.

The core reaches a dual-ported word memory through one port only, made of an address, a read-data input, write data and a write enable. Reads may take one clock of latency, because each address is held for a whole phase. A separate reader can use the memory's other port without any coordination with the core.

A run/stop input selects the mode. In stop mode the phases keep turning and the core keeps fetching and decoding, but it writes nothing: the accumulator, the instruction counter and the store all keep their values. A halt operation sets a sticky indicator, and from then on the core behaves as if it were stopped until the next reset.

Top module: `quad_phase_acc_core`

## Requirements
- R1: While the synchronous active-high reset is asserted, the accumulator and the instruction counter are zero, the phase is Scan1, the halt indicator is low, the write enable is low and the phase enable is high.
- R2: The phase enable is high for HIGH_CYC cycles and low for the remaining PERIOD_CYC−HIGH_CYC cycles of every PERIOD_CYC-cycle period. The phase strobe is high for exactly one cycle per period, in the last low cycle, so the edge that ends the strobe also raises the enable.
- R3: The phase code changes only at a strobe. It steps through Scan1=0, Action1=1, Scan2=2, Action2=3 and then returns to 0.
- R4: During Scan1 and Action1 the memory address is the instruction counter plus one (low 5 bits). During Scan2 and Action2 it is the latched address field. Only instruction bits 4:0 (address) and bits 15:13 (opcode) have any effect. When the core is running, the counter increments at the end of Scan1.
- R5: Opcode 010 loads the negated operand (A := −S). Opcodes 001 and 101 both subtract (A := A − S).
- R6: Opcode 110 raises the write enable for exactly one cycle, on the strobe that ends Action2. The write address is the latched address field and the write data is the accumulator.
- R7: Opcode 000 sets the counter to the operand (CI := S). Opcode 100 adds the operand to it (CI := CI + S).
- R8: Opcode 011 adds one to the counter when accumulator bit 31 is set, and has no effect otherwise.
- R9: Opcode 111 sets the halt indicator. The indicator stays high until reset, and while it is high the core behaves as in stop mode.
- R10: With run low, the phases and the fetch continue, but the accumulator, the counter and the store do not change.
- R11: The run level in the strobe cycle that ends Action2 alone decides whether that instruction's result is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | 1 = run, 0 = stop |
| mem_addr_o | output | 5 | Store address for this phase |
| mem_rdata_i | input | 32 | Store read data (0 or 1 cycle latency) |
| mem_wdata_o | output | 32 | Write data (accumulator) |
| mem_we_o | output | 1 | One-cycle store write enable |
| phase_en_o | output | 1 | Asymmetric phase enable waveform |
| phase_stb_o | output | 1 | One-cycle strobe that ends a phase |
| phase_o | output | 2 | Current phase code |
| acc_o | output | 32 | Accumulator |
| ci_o | output | 32 | Instruction counter |
| halted_o | output | 1 | Halt indicator |

## Verification
Two events can land on the same edge: the write-back of a store instruction and a change of the run/stop input. The bench forces the collision. It waits for the cycle in which the strobe is high during Action2, and in that same cycle it raises run in one case and lowers it in the other. It then judges only what the memory port leaves behind: the stored word is either overwritten with the accumulator or left at its marker value, and the count of write pulses must match.

// File: rtl/qpa_pkg.sv
package qpa_pkg;

  typedef enum logic [1:0] {
    PH_SCAN1 = 2'd0,
    PH_ACT1  = 2'd1,
    PH_SCAN2 = 2'd2,
    PH_ACT2  = 2'd3
  } phase_e;

  typedef enum logic [2:0] {
    OP_JMP  = 3'b000,
    OP_SUB  = 3'b001,
    OP_LDN  = 3'b010,
    OP_SKN  = 3'b011,
    OP_JRP  = 3'b100,
    OP_SUB2 = 3'b101,
    OP_STO  = 3'b110,
    OP_HLT  = 3'b111
  } op_e;

  localparam int OP_W = 3;

endpackage

// File: rtl/qpa_pacer.sv
module qpa_pacer #(
  parameter int PERIOD_CYC = 18000,
  parameter int HIGH_CYC   = 16000
) (
  input  logic clk,
  input  logic rst,
  output logic en,
  output logic stb
);
  localparam int CNT_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);
  localparam logic [CNT_W-1:0] HIGH = CNT_W'(HIGH_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign en  = (cnt_q < HIGH);
  assign stb = wrap;

  // R2
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    stb |=> !stb);

  // R2
  en_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |-> $past(stb));

endmodule

// File: rtl/qpa_sequencer.sv
module qpa_sequencer
  import qpa_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   stb,
  output phase_e phase
);
  phase_e phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_SCAN1;
    end else if (stb) begin
      phase_q <= phase_e'(phase_q + 2'd1);
    end
  end

  assign phase = phase_q;

  // R3
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(phase_q));

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    stb |=> (phase_q == phase_e'($past(phase_q) + 2'd1)));

endmodule

// File: rtl/qpa_exec.sv
module qpa_exec
  import qpa_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 5,
  parameter int OP_LSB = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              stb,
  input  phase_e            phase,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [WORD_W-1:0] acc,
  output logic [WORD_W-1:0] ci,
  output logic              halted
);

  function automatic logic [WORD_W-1:0] f_neg(input logic [WORD_W-1:0] s);
    return (~s) + WORD_W'(1);
  endfunction

  function automatic logic [WORD_W-1:0] f_sub(input logic [WORD_W-1:0] a,
                                              input logic [WORD_W-1:0] s);
    return a - s;
  endfunction

  function automatic logic [WORD_W-1:0] f_rel(input logic [WORD_W-1:0] c,
                                              input logic [WORD_W-1:0] s);
    return c + s;
  endfunction

  function automatic logic f_is_neg(input logic [WORD_W-1:0] a);
    return a[WORD_W-1];
  endfunction

  logic [WORD_W-1:0] acc_q, ci_q, opnd_q;
  logic              halted_q;
  op_e               f_op_q, op_lat;
  logic [ADDR_W-1:0] f_ad_q, ad_lat;

  logic live;
  logic end_scan1, end_act1, end_scan2, end_act2;
  logic exec_fire;
  logic [ADDR_W-1:0] fetch_addr;

  assign live      = run && !halted_q;
  assign end_scan1 = stb && (phase == PH_SCAN1);
  assign end_act1  = stb && (phase == PH_ACT1);
  assign end_scan2 = stb && (phase == PH_SCAN2);
  assign end_act2  = stb && (phase == PH_ACT2);
  assign exec_fire = end_act2 && live;

  assign fetch_addr = ci_q[ADDR_W-1:0] + ADDR_W'(1);

  always_comb begin
    case (phase)
      PH_SCAN1, PH_ACT1: mem_addr = fetch_addr;
      default:           mem_addr = ad_lat;
    endcase
  end

  assign mem_we    = exec_fire && (op_lat == OP_STO);
  assign mem_wdata = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      ci_q     <= '0;
      opnd_q   <= '0;
      halted_q <= 1'b0;
      f_op_q   <= OP_JMP;
      f_ad_q   <= '0;
      op_lat   <= OP_JMP;
      ad_lat   <= '0;
    end else begin
      if (end_scan1) begin
        f_op_q <= op_e'(mem_rdata[OP_LSB +: OP_W]);
        f_ad_q <= mem_rdata[ADDR_W-1:0];
        if (live) ci_q <= ci_q + WORD_W'(1);
      end
      if (end_act1) begin
        op_lat <= f_op_q;
        ad_lat <= f_ad_q;
      end
      if (end_scan2) begin
        opnd_q <= mem_rdata;
      end
      if (exec_fire) begin
        case (op_lat)
          OP_JMP:          ci_q   <= opnd_q;
          OP_JRP:          ci_q   <= f_rel(ci_q, opnd_q);
          OP_LDN:          acc_q  <= f_neg(opnd_q);
          OP_SUB, OP_SUB2: acc_q  <= f_sub(acc_q, opnd_q);
          OP_SKN:          if (f_is_neg(acc_q)) ci_q <= ci_q + WORD_W'(1);
          OP_HLT:          halted_q <= 1'b1;
          default:         ;
        endcase
      end
    end
  end

  assign acc    = acc_q;
  assign ci     = ci_q;
  assign halted = halted_q;

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted_q |=> halted_q);

  // R10
  stop_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !live |=> ($stable(acc_q) && $stable(ci_q)));

  // R6
  we_phase_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (phase == PH_ACT2) && stb);

  // R6
  we_single_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R4
  ci_step_chk: assert property (@(posedge clk) disable iff (rst)
    (end_scan1 && live) |=> (ci_q == $past(ci_q) + WORD_W'(1)));

  // R3
  quiet_between_chk: assert property (@(posedge clk) disable iff (rst)
    !stb |=> ($stable(acc_q) && $stable(ci_q) && $stable(halted_q)));

endmodule

// File: rtl/quad_phase_acc_core.sv
module quad_phase_acc_core
  import qpa_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int WORDS      = 32,
  parameter int OP_LSB     = 13,
  parameter int PERIOD_CYC = 18000,
  parameter int HIGH_CYC   = 16000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      run_i,
  output logic [$clog2(WORDS)-1:0]  mem_addr_o,
  input  logic [WORD_W-1:0]         mem_rdata_i,
  output logic [WORD_W-1:0]         mem_wdata_o,
  output logic                      mem_we_o,
  output logic                      phase_en_o,
  output logic                      phase_stb_o,
  output logic [1:0]                phase_o,
  output logic [WORD_W-1:0]         acc_o,
  output logic [WORD_W-1:0]         ci_o,
  output logic                      halted_o
);
  localparam int ADDR_W = $clog2(WORDS);

  logic   en_w, stb_w;
  phase_e phase_w;

  qpa_pacer #(
    .PERIOD_CYC (PERIOD_CYC),
    .HIGH_CYC   (HIGH_CYC)
  ) pacer_i (
    .clk (clk),
    .rst (rst),
    .en  (en_w),
    .stb (stb_w)
  );

  qpa_sequencer seq_i (
    .clk   (clk),
    .rst   (rst),
    .stb   (stb_w),
    .phase (phase_w)
  );

  qpa_exec #(
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W),
    .OP_LSB (OP_LSB)
  ) exec_i (
    .clk       (clk),
    .rst       (rst),
    .run       (run_i),
    .stb       (stb_w),
    .phase     (phase_w),
    .mem_rdata (mem_rdata_i),
    .mem_addr  (mem_addr_o),
    .mem_we    (mem_we_o),
    .mem_wdata (mem_wdata_o),
    .acc       (acc_o),
    .ci        (ci_o),
    .halted    (halted_o)
  );

  assign phase_en_o  = en_w;
  assign phase_stb_o = stb_w;
  assign phase_o     = phase_w;

endmodule

// File: tb/quad_phase_acc_core_tb_top.sv
`timescale 1ns/1ps
module quad_phase_acc_core_tb_top;
  localparam int PER  = 9;
  localparam int HIGH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic [4:0]  mem_addr;
  logic [31:0] mem_rdata, mem_wdata, acc, ci;
  logic        mem_we, ph_en, ph_stb, halted;
  logic [1:0]  phase;

  logic [31:0] mem [32];
  int n_tests = 0;
  int n_fail  = 0;
  int we_seen = 0;

  always #2 clk = ~clk;

  quad_phase_acc_core #(.PERIOD_CYC(PER), .HIGH_CYC(HIGH)) dut_i (
    .clk(clk), .rst(rst), .run_i(run),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .phase_en_o(ph_en), .phase_stb_o(ph_stb), .phase_o(phase),
    .acc_o(acc), .ci_o(ci), .halted_o(halted)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      we_seen <= we_seen + 1;
    end
    mem_rdata <= mem[mem_addr];
  end

  function automatic logic [31:0] enc(input logic [2:0] op, input logic [4:0] a);
    return 32'hA5A5_0A60 | (32'(op) << 13) | 32'(a);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 32; i++) mem[i] = 32'h0;
  endtask

  task automatic do_reset(input logic run_lvl);
    rst = 1'b1;
    run = run_lvl;
    repeat (3) @(negedge clk);
    we_seen = 0;
    rst = 1'b0;
  endtask

  task automatic next_instr();
    do @(negedge clk); while (!(ph_stb && phase == 2'd3));
    @(negedge clk);
  endtask

  task automatic t_reset();
    clear_mem();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 acc", acc, 0);
    chk("R1 ci", ci, 0);
    chk("R1 phase", 32'(phase), 0);
    chk("R1 halted", 32'(halted), 0);
    chk("R1 we", 32'(mem_we), 0);
    chk("R1 en", 32'(ph_en), 1);
  endtask

  task automatic t_pacer();
    int hi = 0, st = 0, bad = 0;
    logic [1:0] seen [4];
    logic prev_stb = 1'b0;
    clear_mem();
    do_reset(1'b0);
    for (int i = 0; i < 4 * PER; i++) begin
      @(negedge clk);
      if (ph_en) hi++;
      if (prev_stb && !ph_en) bad++;
      if (ph_stb) begin
        if (ph_en) bad++;
        if (st < 4) seen[st] = phase;
        st++;
      end
      prev_stb = ph_stb;
    end
    chk("R2 enable high cycles", hi, 4 * HIGH);
    chk("R2 strobe count", st, 4);
    chk("R2 strobe/enable alignment", bad, 0);
    for (int k = 0; k < 4; k++) chk("R3 phase order", 32'(seen[k]), k);
  endtask

  task automatic t_program();
    clear_mem();
    mem[1]  = enc(3'b010, 5'd20);
    mem[2]  = enc(3'b001, 5'd21);
    mem[3]  = enc(3'b110, 5'd22);
    mem[4]  = enc(3'b011, 5'd0);
    mem[5]  = enc(3'b111, 5'd0);
    mem[6]  = enc(3'b000, 5'd23);
    mem[10] = enc(3'b100, 5'd24);
    mem[16] = enc(3'b101, 5'd25);
    mem[17] = enc(3'b010, 5'd26);
    mem[18] = enc(3'b011, 5'd0);
    mem[19] = enc(3'b111, 5'd0);
    mem[20] = 32'd5;  mem[21] = 32'd3;  mem[22] = 32'h1234;
    mem[23] = 32'd9;  mem[24] = 32'd5;  mem[25] = 32'd1;
    mem[26] = -32'sd7;
    do_reset(1'b1);
    next_instr(); chk("R5 load negated", acc, -32'sd5); chk("R4 ci step", ci, 1);
    next_instr(); chk("R5 subtract 001", acc, -32'sd8);
    next_instr(); chk("R6 store data", mem[22], -32'sd8); chk("R6 one write", we_seen, 1);
    next_instr(); chk("R8 skip taken", ci, 5);
    next_instr(); chk("R7 indirect jump", ci, 9);
    next_instr(); chk("R7 relative jump", ci, 15);
    next_instr(); chk("R5 subtract 101", acc, -32'sd9);
    next_instr(); chk("R4 junk bits ignored, load", acc, 7);
    next_instr(); chk("R8 skip not taken", ci, 18);
    next_instr(); chk("R9 halt set", 32'(halted), 1); chk("R9 ci at halt", ci, 19);
    next_instr(); next_instr();
    chk("R9 halt sticky", 32'(halted), 1);
    chk("R9 ci frozen", ci, 19);
    chk("R9 acc frozen", acc, 7);
    chk("R9 no further writes", we_seen, 1);
  endtask

  task automatic t_stop_and_race();
    clear_mem();
    mem[1]  = enc(3'b110, 5'd22);
    mem[22] = 32'h1234;
    do_reset(1'b0);
    next_instr();
    chk("R10 ci held", ci, 0);
    chk("R10 acc held", acc, 0);
    chk("R10 store held", mem[22], 32'h1234);
    chk("R10 no write", we_seen, 0);
    chk("R4 fetch address in stop", 32'(mem_addr), 1);
    do @(negedge clk); while (phase != 2'd2);
    chk("R4 operand address from field", 32'(mem_addr), 22);
    do @(negedge clk); while (!(ph_stb && phase == 2'd3));
    run = 1'b1;
    @(negedge clk);
    chk("R11 run raised at write edge", mem[22], 0);
    chk("R11 write count", we_seen, 1);
    chk("R11 ci not stepped in stop fetch", ci, 0);

    clear_mem();
    mem[1]  = enc(3'b110, 5'd22);
    mem[22] = 32'h1234;
    do_reset(1'b1);
    do @(negedge clk); while (!(ph_stb && phase == 2'd3));
    run = 1'b0;
    @(negedge clk);
    chk("R11 run dropped at write edge", mem[22], 32'h1234);
    chk("R11 no write", we_seen, 0);
    chk("R4 ci stepped while running", ci, 1);
  endtask

  initial begin
    t_reset();
    t_pacer();
    t_program();
    t_stop_and_race();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule